// File: doc/BRIEF.md
# Cascaded Interrupt Controller Programming Front End

This block is the register side of a pair of cascaded 8259-style interrupt controllers. Each controller has its own one-bit port select, write strobe, read strobe and 8-bit write data. Port 0 sits at I/O address 0x20 for the first controller and 0xA0 for the second. Port 1 sits at 0x21 and 0xA1. The address decode that produces the port select lies outside this block.

Each controller runs a small sequencer for its initialization words. It holds the interrupt mask and the interrupt vector base. Operation-control words are turned into end-of-interrupt pulses, a read-back select and a special-mask flag. These results feed a separate priority dispatcher. That dispatcher owns the request and in-service registers and hands them back so that software can read them.

Only a reduced command set is decoded. The third and fourth initialization words keep the sequence aligned and have no other effect. Every end-of-interrupt command is passed on as one pulse aimed at the interrupt now in service, and the level field of the command is ignored.

Top module: `cascade_pic_regs`

## Requirements
- R1: After reset, every controller shows a mask of MASK_RST (default 8'hFF), a vector base of 0 and special mask mode off. A port-0 read returns the request register.
- R2: A write to port 0 with bit 4 set starts initialization from any state, including part-way through a sequence. On the next cycle the mask is 0, special mask mode is off and the read select points to the request register. Bits 1:0 of the write give the number of further initialization words to take, from 0 to 3.
- R3: The first further initialization word is a port-1 write. It loads the vector base from its bits 7:3.
- R4: Any remaining initialization words are port-1 writes. They are counted off and change neither the mask nor the vector base.
- R5: While initialization words are still owed, a port-0 write with bit 4 clear is ignored. It produces no end-of-interrupt pulse and does not change the read select.
- R6: Once the sequence is complete, a port-1 write loads all 8 bits into the mask.
- R7: Outside initialization, a port-0 write with bits 4 and 3 both clear is an OCW2. If bit 5 is set and bit 7 is clear, eoi_o pulses high for exactly the next cycle, whatever bits 6 and 2:0 hold. Any other value produces no pulse.
- R8: Outside initialization, a port-0 write with bit 4 clear and bit 3 set is an OCW3. Bits 1:0 = 2'b10 select the request register for port-0 reads, and 2'b11 select the in-service register. Any other value leaves the select unchanged.
- R9: In an OCW3, bits 6:5 = 2'b11 turn special mask mode on and 2'b10 turn it off. Any other value leaves it unchanged.
- R10: The read data is combinational in the same cycle as the read strobe. A port-1 read returns the mask, and a port-0 read returns the selected register. While the read strobe is low, the read data is 0.
- R11: The controllers are independent. A write to one controller changes no output of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_i | input | NUM_CTRL | Write strobe, one bit per controller |
| rd_i | input | NUM_CTRL | Read strobe, one bit per controller |
| a0_i | input | NUM_CTRL | Port select (0 or 1), one bit per controller |
| wdata_i | input | 8*NUM_CTRL | Write data, byte c belongs to controller c |
| irr_i | input | 8*NUM_CTRL | Request register from the dispatcher, for read-back |
| isr_i | input | 8*NUM_CTRL | In-service register from the dispatcher, for read-back |
| rdata_o | output | 8*NUM_CTRL | Read data per controller |
| mask_o | output | 8*NUM_CTRL | Interrupt mask per controller |
| vbase_o | output | 5*NUM_CTRL | Vector base (bits 7:3 of the vector) per controller |
| eoi_o | output | NUM_CTRL | One-cycle end-of-interrupt pulse per controller |
| smm_o | output | NUM_CTRL | Special mask mode flag per controller |

## Verification
The bench uses the default build: two controllers and a reset mask of 8'hFF. With that build, a mask that the initialization word has cleared can be told apart from the reset value. Cross-talk between the master and the slave controller can also be watched on every command. The directed cases cover:
- initialization sequences of zero, one and three further words;
- a restart in the middle of a sequence;
- commands that arrive while words are still owed;
- the full set of OCW3 field values that do and do not act.

// File: rtl/pic_if_pkg.sv
package pic_if_pkg;

    localparam int PIC_DW = 8;
    localparam int PIC_VW = PIC_DW - 3;
    localparam int PIC_CW = 2;

    // command bit positions fixed by the programming protocol
    localparam int ICW1_FLAG_BIT = 4;
    localparam int OCW3_FLAG_BIT = 3;
    localparam int EOI_BIT       = 5;
    localparam int ROT_BIT       = 7;
    localparam int SEL_VALID_BIT = 1;
    localparam int SEL_ISR_BIT   = 0;
    localparam int SMM_VALID_BIT = 6;
    localparam int SMM_VAL_BIT   = 5;

    localparam logic [PIC_CW-1:0] CNT_ONE = PIC_CW'(1);

    typedef enum logic [2:0] {
        WK_NONE,
        WK_ICW1,
        WK_ICW_NEXT,
        WK_OCW1,
        WK_OCW2,
        WK_OCW3,
        WK_DROP
    } wr_kind_e;

    typedef struct packed {
        logic [PIC_DW-1:0] mask;
        logic [PIC_VW-1:0] vbase;
        logic [PIC_CW-1:0] left;
        logic              vec_next;
        logic              sel_isr;
        logic              smm;
        logic              eoi;
    } ctl_state_t;

endpackage

// File: rtl/pic_wr_classify.sv
module pic_wr_classify
    import pic_if_pkg::*;
(
    input  logic     wr_i,
    input  logic     a0_i,
    input  logic     icw1_flag_i,
    input  logic     ocw3_flag_i,
    input  logic     seq_busy_i,
    output wr_kind_e kind_o
);

    always_comb begin
        kind_o = WK_NONE;
        if (wr_i) begin
            if (!a0_i && icw1_flag_i) begin
                kind_o = WK_ICW1;
            end else if (seq_busy_i) begin
                kind_o = a0_i ? WK_ICW_NEXT : WK_DROP;
            end else if (a0_i) begin
                kind_o = WK_OCW1;
            end else if (ocw3_flag_i) begin
                kind_o = WK_OCW3;
            end else begin
                kind_o = WK_OCW2;
            end
        end
    end

endmodule

// File: rtl/pic_ctl_regs.sv
module pic_ctl_regs
    import pic_if_pkg::*;
#(
    parameter logic [PIC_DW-1:0] MASK_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic              a0_i,
    input  logic [PIC_DW-1:0] wdata_i,
    input  logic [PIC_DW-1:0] irr_i,
    input  logic [PIC_DW-1:0] isr_i,
    output logic [PIC_DW-1:0] rdata_o,
    output logic [PIC_DW-1:0] mask_o,
    output logic [PIC_VW-1:0] vbase_o,
    output logic              eoi_o,
    output logic              smm_o
);

    localparam ctl_state_t RST_STATE = '{
        mask:     MASK_RST,
        vbase:    '0,
        left:     '0,
        vec_next: 1'b0,
        sel_isr:  1'b0,
        smm:      1'b0,
        eoi:      1'b0
    };

    ctl_state_t st_q, st_d;
    wr_kind_e   kind;

    pic_wr_classify u_classify (
        .wr_i        (wr_i),
        .a0_i        (a0_i),
        .icw1_flag_i (wdata_i[ICW1_FLAG_BIT]),
        .ocw3_flag_i (wdata_i[OCW3_FLAG_BIT]),
        .seq_busy_i  (st_q.left != '0),
        .kind_o      (kind)
    );

    always_comb begin
        st_d     = st_q;
        st_d.eoi = 1'b0;
        unique case (kind)
            WK_ICW1: begin
                st_d.mask     = '0;
                st_d.left     = wdata_i[PIC_CW-1:0];
                st_d.vec_next = 1'b1;
                st_d.sel_isr  = 1'b0;
                st_d.smm      = 1'b0;
            end
            WK_ICW_NEXT: begin
                if (st_q.vec_next) begin
                    st_d.vbase = wdata_i[PIC_DW-1 -: PIC_VW];
                end
                st_d.vec_next = 1'b0;
                st_d.left     = st_q.left - CNT_ONE;
            end
            WK_OCW1: begin
                st_d.mask = wdata_i;
            end
            WK_OCW2: begin
                // level bits are ignored: every EOI targets the current one
                st_d.eoi = wdata_i[EOI_BIT] & ~wdata_i[ROT_BIT];
            end
            WK_OCW3: begin
                if (wdata_i[SEL_VALID_BIT]) begin
                    st_d.sel_isr = wdata_i[SEL_ISR_BIT];
                end
                if (wdata_i[SMM_VALID_BIT]) begin
                    st_d.smm = wdata_i[SMM_VAL_BIT];
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            if (a0_i) begin
                rdata_o = st_q.mask;
            end else begin
                rdata_o = st_q.sel_isr ? isr_i : irr_i;
            end
        end
    end

    assign mask_o  = st_q.mask;
    assign vbase_o = st_q.vbase;
    assign eoi_o   = st_q.eoi;
    assign smm_o   = st_q.smm;

endmodule

// File: rtl/cascade_pic_regs.sv
module cascade_pic_regs
    import pic_if_pkg::*;
#(
    parameter int                NUM_CTRL = 2,
    parameter logic [PIC_DW-1:0] MASK_RST = '1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CTRL-1:0]        wr_i,
    input  logic [NUM_CTRL-1:0]        rd_i,
    input  logic [NUM_CTRL-1:0]        a0_i,
    input  logic [NUM_CTRL*PIC_DW-1:0] wdata_i,
    input  logic [NUM_CTRL*PIC_DW-1:0] irr_i,
    input  logic [NUM_CTRL*PIC_DW-1:0] isr_i,
    output logic [NUM_CTRL*PIC_DW-1:0] rdata_o,
    output logic [NUM_CTRL*PIC_DW-1:0] mask_o,
    output logic [NUM_CTRL*PIC_VW-1:0] vbase_o,
    output logic [NUM_CTRL-1:0]        eoi_o,
    output logic [NUM_CTRL-1:0]        smm_o
);

    for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctl
        pic_ctl_regs #(
            .MASK_RST (MASK_RST)
        ) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (wr_i[c]),
            .rd_i    (rd_i[c]),
            .a0_i    (a0_i[c]),
            .wdata_i (wdata_i[c*PIC_DW +: PIC_DW]),
            .irr_i   (irr_i[c*PIC_DW +: PIC_DW]),
            .isr_i   (isr_i[c*PIC_DW +: PIC_DW]),
            .rdata_o (rdata_o[c*PIC_DW +: PIC_DW]),
            .mask_o  (mask_o[c*PIC_DW +: PIC_DW]),
            .vbase_o (vbase_o[c*PIC_VW +: PIC_VW]),
            .eoi_o   (eoi_o[c]),
            .smm_o   (smm_o[c])
        );
    end

endmodule

// File: rtl/cascade_pic_regs_chk.sv
module cascade_pic_regs_chk
    import pic_if_pkg::*;
#(
    parameter int NUM_CTRL = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_CTRL-1:0]        wr_i,
    input logic [NUM_CTRL-1:0]        rd_i,
    input logic [NUM_CTRL-1:0]        a0_i,
    input logic [NUM_CTRL*PIC_DW-1:0] wdata_i,
    input logic [NUM_CTRL*PIC_DW-1:0] rdata_o,
    input logic [NUM_CTRL*PIC_DW-1:0] mask_o,
    input logic [NUM_CTRL*PIC_VW-1:0] vbase_o,
    input logic [NUM_CTRL-1:0]        eoi_o,
    input logic [NUM_CTRL-1:0]        smm_o
);

    for (genvar c = 0; c < NUM_CTRL; c++) begin : g_chk
        // R7
        eoi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            eoi_o[c] |-> $past(wr_i[c] && !a0_i[c]
                && !wdata_i[c*PIC_DW + ICW1_FLAG_BIT]
                && !wdata_i[c*PIC_DW + OCW3_FLAG_BIT]
                && wdata_i[c*PIC_DW + EOI_BIT]
                && !wdata_i[c*PIC_DW + ROT_BIT]));

        // R6
        mask_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(mask_o[c*PIC_DW +: PIC_DW]) |-> $past(wr_i[c]));

        // R2
        init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i[c] && !a0_i[c] && wdata_i[c*PIC_DW + ICW1_FLAG_BIT])
            |=> (mask_o[c*PIC_DW +: PIC_DW] == '0 && !smm_o[c]));

        // R9
        smm_port0_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(smm_o[c]) |-> $past(wr_i[c] && !a0_i[c]));

        // R3
        vbase_port1_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(vbase_o[c*PIC_VW +: PIC_VW]) |-> $past(wr_i[c] && a0_i[c]));

        // R10
        read_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_i[c] |-> (rdata_o[c*PIC_DW +: PIC_DW] == '0));

        // R10
        read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_i[c] && a0_i[c]) |-> (rdata_o[c*PIC_DW +: PIC_DW] == mask_o[c*PIC_DW +: PIC_DW]));
    end

endmodule

bind cascade_pic_regs cascade_pic_regs_chk #(
    .NUM_CTRL (NUM_CTRL)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .a0_i    (a0_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .mask_o  (mask_o),
    .vbase_o (vbase_o),
    .eoi_o   (eoi_o),
    .smm_o   (smm_o)
);

// File: tb/cascade_pic_regs_tb_top.sv
`timescale 1ns/1ps
module cascade_pic_regs_tb_top;

    localparam int NC = 2;
    localparam int DW = 8;
    localparam int VW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NC-1:0]   wr = '0;
    logic [NC-1:0]   rd = '0;
    logic [NC-1:0]   a0 = '0;
    logic [NC*DW-1:0] wdata = '0;
    logic [NC*DW-1:0] irr;
    logic [NC*DW-1:0] isr;
    logic [NC*DW-1:0] rdata;
    logic [NC*DW-1:0] mask;
    logic [NC*VW-1:0] vbase;
    logic [NC-1:0]   eoi;
    logic [NC-1:0]   smm;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    assign irr = {8'hC3, 8'h5A};
    assign isr = {8'h24, 8'h81};

    cascade_pic_regs #(.NUM_CTRL(NC)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr),
        .rd_i    (rd),
        .a0_i    (a0),
        .wdata_i (wdata),
        .irr_i   (irr),
        .isr_i   (isr),
        .rdata_o (rdata),
        .mask_o  (mask),
        .vbase_o (vbase),
        .eoi_o   (eoi),
        .smm_o   (smm)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input int c, input logic port, input logic [7:0] d);
        @(negedge clk);
        wr[c] = 1'b1;
        a0[c] = port;
        wdata[c*DW +: DW] = d;
        @(negedge clk);
        wr[c] = 1'b0;
    endtask

    task automatic do_rd(input int c, input logic port, output logic [7:0] d);
        @(negedge clk);
        rd[c] = 1'b1;
        a0[c] = port;
        #2;
        d = rdata[c*DW +: DW];
        rd[c] = 1'b0;
    endtask

    function automatic int mask_of(input int c);
        return int'(mask[c*DW +: DW]);
    endfunction

    function automatic int vb_of(input int c);
        return int'(vbase[c*VW +: VW]);
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        for (int c = 0; c < NC; c++) begin
            check("R1 mask", mask_of(c), 8'hFF);
            check("R1 vbase", vb_of(c), 0);
            check("R1 smm", int'(smm[c]), 0);
            do_rd(c, 1'b0, d);
            check("R1 read select", int'(d), int'(irr[c*DW +: DW]));
        end
    endtask

    task automatic t_short_init();
        logic [7:0] d;
        do_wr(0, 1'b0, 8'h11);
        check("R2 mask cleared", mask_of(0), 0);
        do_wr(0, 1'b1, 8'h20);
        check("R3 vbase", vb_of(0), 4);
        check("R3 mask kept", mask_of(0), 0);
        do_wr(0, 1'b1, 8'hB5);
        check("R6 mask load", mask_of(0), 8'hB5);
        check("R6 vbase kept", vb_of(0), 4);
        do_rd(0, 1'b1, d);
        check("R10 read mask", int'(d), 8'hB5);
        check("R11 other mask", mask_of(1), 8'hFF);
    endtask

    task automatic t_long_init();
        logic [7:0] d;
        do_wr(1, 1'b0, 8'h13);
        check("R2 mask cleared", mask_of(1), 0);
        do_wr(1, 1'b1, 8'h70);
        check("R3 vbase", vb_of(1), 14);
        do_wr(1, 1'b0, 8'h20);
        check("R5 no eoi in init", int'(eoi[1]), 0);
        do_wr(1, 1'b0, 8'h0B);
        do_rd(1, 1'b0, d);
        check("R5 select kept", int'(d), int'(irr[DW +: DW]));
        do_wr(1, 1'b1, 8'h02);
        check("R4 mask kept", mask_of(1), 0);
        check("R4 vbase kept", vb_of(1), 14);
        do_wr(1, 1'b1, 8'hF9);
        check("R4 mask kept 2", mask_of(1), 0);
        check("R4 vbase kept 2", vb_of(1), 14);
        do_wr(1, 1'b1, 8'h3C);
        check("R6 mask after init", mask_of(1), 8'h3C);
        check("R11 other mask", mask_of(0), 8'hB5);
        check("R11 other vbase", vb_of(0), 4);
    endtask

    task automatic t_restart();
        do_wr(0, 1'b0, 8'h13);
        do_wr(0, 1'b1, 8'h48);
        check("R3 vbase", vb_of(0), 9);
        do_wr(0, 1'b0, 8'h10);
        check("R2 restart mask", mask_of(0), 0);
        do_wr(0, 1'b1, 8'h0F);
        check("R2 zero words mask", mask_of(0), 8'h0F);
        check("R2 zero words vbase", vb_of(0), 9);
    endtask

    task automatic t_eoi();
        logic [7:0] codes [6] = '{8'h20, 8'h67, 8'hA0, 8'hE3, 8'h40, 8'h07};
        int         pulse [6] = '{1, 1, 0, 0, 0, 0};
        for (int i = 0; i < 6; i++) begin
            do_wr(0, 1'b0, codes[i]);
            check("R7 eoi pulse", int'(eoi[0]), pulse[i]);
            check("R11 other eoi", int'(eoi[1]), 0);
            @(negedge clk);
            check("R7 eoi one cycle", int'(eoi[0]), 0);
        end
        check("R7 mask untouched", mask_of(0), 8'h0F);
    endtask

    task automatic t_ocw3();
        logic [7:0] d;
        do_wr(0, 1'b0, 8'h0B);
        do_rd(0, 1'b0, d);
        check("R8 select isr", int'(d), 8'h81);
        do_wr(0, 1'b0, 8'h08);
        do_rd(0, 1'b0, d);
        check("R8 select kept", int'(d), 8'h81);
        do_wr(0, 1'b0, 8'h09);
        do_rd(0, 1'b0, d);
        check("R8 select kept 01", int'(d), 8'h81);
        do_wr(0, 1'b0, 8'h0A);
        do_rd(0, 1'b0, d);
        check("R8 select irr", int'(d), 8'h5A);
        do_wr(0, 1'b0, 8'h68);
        check("R9 smm on", int'(smm[0]), 1);
        check("R11 other smm", int'(smm[1]), 0);
        do_wr(0, 1'b0, 8'h28);
        check("R9 smm kept", int'(smm[0]), 1);
        do_wr(0, 1'b0, 8'h48);
        check("R9 smm off", int'(smm[0]), 0);
        do_wr(0, 1'b0, 8'h6B);
        check("R9 smm on again", int'(smm[0]), 1);
        do_wr(0, 1'b0, 8'h10);
        check("R2 smm cleared", int'(smm[0]), 0);
        do_rd(0, 1'b0, d);
        check("R2 select reset", int'(d), 8'h5A);
        do_wr(0, 1'b1, 8'hAA);
        check("R6 mask after zero-word init", mask_of(0), 8'hAA);
    endtask

    task automatic t_idle_read();
        @(negedge clk);
        #2;
        check("R10 idle read c0", int'(rdata[0 +: DW]), 0);
        check("R10 idle read c1", int'(rdata[DW +: DW]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short_init();
        t_long_init();
        t_restart();
        t_eoi();
        t_ocw3();
        t_idle_read();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule